// File: doc/BRIEF.md
# Temperature Event Controller

This block watches a stream of signed digital temperature readings and drives a low-true event pin from them. Three programmable limits are held in registers: an upper and a lower bound that form an alarm window, and a critical limit. Each limit has a status flag with hysteresis. The flag sets as soon as a reading goes past the limit. It clears only once a reading has come back inside the limit by the programmed hysteresis amount.

A configuration register picks how the flags reach the pin. In compare mode the pin follows the flags directly. In interrupt mode a new window violation latches the pin until a software clear strobe. In critical-only mode the window is ignored. In every mode the critical flag drives the pin directly, and the clear strobe cannot remove it.

The sensor converter and the serial register transport sit outside this block. They present readings on a valid strobe and registers on a simple write port.

Top module: `temp_event_ctrl`

## Requirements
- R1: After reset `event_n` is 1 and `st_above`, `st_below` and `st_crit` are 0. The limits reset to values that no reading can trip: upper = +1023, lower = -1024, critical = +1023.
- R2: Readings and limits are 11-bit two's complement in quarter degrees, compared signed. `st_above` sets on a valid reading strictly greater than the upper limit. It clears on a valid reading <= upper - H. Otherwise it holds.
- R3: `st_below` sets on a valid reading strictly less than the lower limit. It clears on a valid reading >= lower + H. Otherwise it holds.
- R4: `st_crit` sets on a valid reading strictly greater than the critical limit. It clears on a valid reading <= critical - H. Otherwise it holds. H is set by the 2-bit hysteresis code: 0→0, 1→6, 2→12, 3→24 quarter degrees (0, 1.5, 3 and 6 degrees).
- R5: The flags change only on a cycle with `smp_valid` high. The flags and `event_n` show the new result right after the clock edge that takes the reading.
- R6: Compare mode (mode code 1, and reserved code 3) drives the event while (window enabled and (`st_above` or `st_below`)) or `st_crit` is set. `sw_clr` has no effect in this mode.
- R7: Interrupt mode (mode code 0) latches the event on a valid reading that newly sets `st_above` or `st_below` while the window is enabled. The latch holds after the reading returns inside the window and is cleared by `sw_clr`. When a clear and a new violation arrive in the same cycle, the violation wins. A reading that stays outside the window does not set the latch again.
- R8: In interrupt mode a set `st_crit` asserts the event regardless of the latch, and `sw_clr` does not deassert it.
- R9: Critical-only mode (mode code 2) drives the event from `st_crit` alone. Window flags are still reported but do not reach the pin.
- R10: While the event-enable bit is 0, `event_n` stays 1. The flags still update, and the event appears once the bit is set.
- R11: With the window-enable bit at 0, upper and lower violations do not assert the event. Their status flags still update.
- R12: Register writes take effect on the edge where `wr_en` is high. `wr_sel` 0 selects config, 1 upper, 2 lower and 3 critical; limits take `wr_data`. Config fields are: bit 0 event enable, bits 2:1 mode, bits 4:3 hysteresis code, bit 5 window enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Reading valid strobe |
| smp_temp | input | 11 | Signed reading, quarter degrees |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | 11 | Register write data |
| sw_clr | input | 1 | Software clear strobe |
| event_n | output | 1 | Event pin, low when active |
| st_above | output | 1 | Above-upper status flag |
| st_below | output | 1 | Below-lower status flag |
| st_crit | output | 1 | Above-critical status flag |

## Verification
The bench probes each limit exactly at the limit and exactly one hysteresis step back from it. A design that compares non-strictly, or applies hysteresis in the wrong direction or with the wrong code table, shows a flag one reading too early or too late. A positive reading is checked against a negative upper limit to catch an unsigned compare. The interrupt tests cover three cases: a clear arriving together with a new violation, a repeated reading that stays outside the window, and a clear issued while the critical flag is set. A design with wrong latch priority or clearable critical behaviour leaves the pin at the wrong level in these cases. The enable and window-enable bits are toggled with flags active, which exposes a pin that ignores either gate.

// File: rtl/temp_event_pkg.sv
package temp_event_pkg;

  typedef enum logic [1:0] {
    MODE_INT  = 2'd0,
    MODE_CMP  = 2'd1,
    MODE_CRIT = 2'd2,
    MODE_RSV  = 2'd3
  } evt_mode_e;

  // bit0 enable, bits2:1 mode, bits4:3 hysteresis code, bit5 window enable
  typedef struct packed {
    logic      win_en;
    logic [1:0] hyst;
    evt_mode_e mode;
    logic      evt_en;
  } evt_cfg_t;

  localparam int CFG_W = 6;

  // hysteresis code to quarter degrees
  function automatic int hyst_quarters(input logic [1:0] code);
    case (code)
      2'd0:    return 0;
      2'd1:    return 6;
      2'd2:    return 12;
      default: return 24;
    endcase
  endfunction

  // reading has gone past the limit
  function automatic logic past_limit(input int t, input int lim, input logic upward);
    return upward ? (t > lim) : (t < lim);
  endfunction

  // reading has come back inside the limit by the hysteresis amount
  function automatic logic back_inside(input int t, input int lim, input int hq,
                                       input logic upward);
    return upward ? (t <= lim - hq) : (t >= lim + hq);
  endfunction

endpackage

// File: rtl/tev_regs.sv
module tev_regs
  import temp_event_pkg::*;
#(
  parameter int TW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [TW-1:0] wr_data,
  output evt_cfg_t      cfg,
  output logic [TW-1:0] lim_hi,
  output logic [TW-1:0] lim_lo,
  output logic [TW-1:0] lim_crit
);

  localparam logic [TW-1:0] POS_MAX = {1'b0, {(TW-1){1'b1}}};
  localparam logic [TW-1:0] NEG_MIN = {1'b1, {(TW-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg      <= '0;
      lim_hi   <= POS_MAX;
      lim_lo   <= NEG_MIN;
      lim_crit <= POS_MAX;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0:    cfg      <= evt_cfg_t'(wr_data[CFG_W-1:0]);
        2'd1:    lim_hi   <= wr_data;
        2'd2:    lim_lo   <= wr_data;
        default: lim_crit <= wr_data;
      endcase
    end
  end

endmodule

// File: rtl/tev_limit_cmp.sv
module tev_limit_cmp
  import temp_event_pkg::*;
#(
  parameter int TW     = 11,
  parameter bit UPWARD = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [TW-1:0] smp_temp,
  input  logic [TW-1:0] limit,
  input  logic [1:0]    hyst_code,
  output logic          flag,
  output logic          enter
);

  int   t_i, l_i, h_i;
  logic trip, relax;

  assign t_i = int'($signed(smp_temp));
  assign l_i = int'($signed(limit));
  assign h_i = hyst_quarters(hyst_code);

  always_comb begin
    trip  = past_limit(t_i, l_i, UPWARD);
    relax = back_inside(t_i, l_i, h_i, UPWARD);
    enter = smp_valid & trip & ~flag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            flag <= 1'b0;
    else if (smp_valid) begin
      if (trip)            flag <= 1'b1;
      else if (relax)      flag <= 1'b0;
    end
  end

  // R5: flag only moves on a valid reading
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(flag));

  // R2 (and R3, R4 through the other instances): entry sets the flag
  assert_trip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> flag);

endmodule

// File: rtl/tev_event_out.sv
module tev_event_out
  import temp_event_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  evt_cfg_t cfg,
  input  logic     flag_hi,
  input  logic     flag_lo,
  input  logic     flag_crit,
  input  logic     enter_hi,
  input  logic     enter_lo,
  input  logic     sw_clr,
  output logic     event_n
);

  logic latch_q;
  logic win_entry;
  logic win_now;
  logic evt;

  assign win_entry = cfg.win_en & (enter_hi | enter_lo);
  assign win_now   = cfg.win_en & (flag_hi | flag_lo);

  always_ff @(posedge clk) begin
    if (!rst_n)                 latch_q <= 1'b0;
    else if (cfg.mode != MODE_INT) latch_q <= 1'b0;
    else if (win_entry)         latch_q <= 1'b1;
    else if (sw_clr)            latch_q <= 1'b0;
  end

  always_comb begin
    case (cfg.mode)
      MODE_INT:  evt = (cfg.win_en & latch_q) | flag_crit;
      MODE_CRIT: evt = flag_crit;
      default:   evt = win_now | flag_crit;
    endcase
  end

  assign event_n = ~(cfg.evt_en & evt);

  // R7: latch holds without a clear
  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MODE_INT && latch_q && !sw_clr) |=> latch_q);

  // R7: a clear with no new entry empties the latch
  assert_latch_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MODE_INT && sw_clr && !win_entry) |=> !latch_q);

  // R9: critical-only pin idle without critical flag
  assert_critonly_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MODE_CRIT && !flag_crit) |-> event_n);

endmodule

// File: rtl/temp_event_ctrl.sv
module temp_event_ctrl
  import temp_event_pkg::*;
#(
  parameter int TW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [TW-1:0] smp_temp,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [TW-1:0] wr_data,
  input  logic          sw_clr,
  output logic          event_n,
  output logic          st_above,
  output logic          st_below,
  output logic          st_crit
);

  localparam int NLIM     = 3;
  localparam int IDX_HI   = 0;
  localparam int IDX_LO   = 1;
  localparam int IDX_CRIT = 2;

  evt_cfg_t      cfg;
  logic [TW-1:0] lim_arr [NLIM];
  logic [NLIM-1:0] flag_v;
  logic [NLIM-1:0] enter_v;

  tev_regs #(.TW(TW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .cfg      (cfg),
    .lim_hi   (lim_arr[IDX_HI]),
    .lim_lo   (lim_arr[IDX_LO]),
    .lim_crit (lim_arr[IDX_CRIT])
  );

  for (genvar g = 0; g < NLIM; g++) begin : g_lim
    tev_limit_cmp #(.TW(TW), .UPWARD(g != IDX_LO)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .smp_temp  (smp_temp),
      .limit     (lim_arr[g]),
      .hyst_code (cfg.hyst),
      .flag      (flag_v[g]),
      .enter     (enter_v[g])
    );
  end

  tev_event_out u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg),
    .flag_hi   (flag_v[IDX_HI]),
    .flag_lo   (flag_v[IDX_LO]),
    .flag_crit (flag_v[IDX_CRIT]),
    .enter_hi  (enter_v[IDX_HI]),
    .enter_lo  (enter_v[IDX_LO]),
    .sw_clr    (sw_clr),
    .event_n   (event_n)
  );

  assign st_above = flag_v[IDX_HI];
  assign st_below = flag_v[IDX_LO];
  assign st_crit  = flag_v[IDX_CRIT];

  // R8: critical flag always drives the pin when enabled
  assert_crit_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.evt_en && st_crit) |-> !event_n);

  // R4: a critical entry is visible as a status flag
  assert_crit_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    enter_v[IDX_CRIT] |=> st_crit);

  // R10: pin idle while disabled
  assert_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.evt_en |-> event_n);

  // R11: window violations alone never reach the pin with window off
  assert_win_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.win_en && !st_crit) |-> event_n);

endmodule

// File: tb/temp_event_ctrl_tb.sv
module temp_event_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TW = 11;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          smp_valid;
  logic [TW-1:0] smp_temp;
  logic          wr_en;
  logic [1:0]    wr_sel;
  logic [TW-1:0] wr_data;
  logic          sw_clr;
  logic          event_n, st_above, st_below, st_crit;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  temp_event_ctrl #(.TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_temp(smp_temp),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .sw_clr(sw_clr),
    .event_n(event_n), .st_above(st_above), .st_below(st_below), .st_crit(st_crit)
  );

  // mode codes: 0 interrupt, 1 compare, 2 critical-only
  function automatic logic [TW-1:0] cfg_word(input bit en, input int mode,
                                            input int hyst, input bit win);
    logic [TW-1:0] w;
    w = '0;
    w[0]   = en;
    w[2:1] = mode[1:0];
    w[4:3] = hyst[1:0];
    w[5]   = win;
    return w;
  endfunction

  // expected {event_n, above, below, crit}
  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {event_n, st_above, st_below, st_crit};
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {event_n,above,below,crit} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic sample(input int t, input bit clr = 1'b0);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_temp  = t[TW-1:0];
    sw_clr    = clr;
    @(negedge clk);
    smp_valid = 1'b0;
    sw_clr    = 1'b0;
  endtask

  task automatic write_reg(input int sel, input logic [TW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel[1:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    sw_clr = 1'b1;
    @(negedge clk);
    sw_clr = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; smp_valid = 0; smp_temp = '0; wr_en = 0; wr_sel = '0;
    wr_data = '0; sw_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", 4'b1000);
    sample(1000);
    check("R1 reset limits untrippable", 4'b1000);
  endtask

  task automatic t_upper_cmp();
    int v100 = 100;
    write_reg(1, v100[TW-1:0]);
    write_reg(2, 11'h7D8);     // -40
    write_reg(3, 11'd200);
    write_reg(0, cfg_word(1, 1, 1, 1));
    sample(100);  check("R2 equal to upper not tripped", 4'b1000);
    sample(101);  check("R2 above upper sets flag R6 pin", 4'b0100);
    sample(96);   check("R2 inside but within hysteresis holds", 4'b0100);
    @(negedge clk); smp_temp = 11'h60C;   // -500, valid low
    @(negedge clk);
    check("R5 no valid no change", 4'b0100);
    sample(94);   check("R2 back by hysteresis clears R6", 4'b1000);
  endtask

  task automatic t_lower_cmp();
    write_reg(0, cfg_word(1, 1, 2, 1));
    sample(-41);  check("R3 below lower sets flag", 4'b0010);
    pulse_clr();  check("R6 clear ignored in compare", 4'b0010);
    sample(-30);  check("R3 within hysteresis holds", 4'b0010);
    sample(-28);  check("R3 back by hysteresis clears", 4'b1000);
  endtask

  task automatic t_interrupt();
    write_reg(0, cfg_word(1, 0, 0, 1));
    sample(150);  check("R7 violation latches", 4'b0100);
    sample(50);   check("R7 latch holds after return", 4'b0000);
    pulse_clr();  check("R7 clear releases", 4'b1000);
    sample(150, 1'b1); check("R7 new violation beats clear", 4'b0100);
    pulse_clr();  check("R7 clear with flag still set", 4'b1100);
    sample(160);  check("R7 staying outside does not relatch", 4'b1100);
  endtask

  task automatic t_crit_int();
    sample(250);  check("R8 critical asserts in interrupt", 4'b0101);
    pulse_clr();  check("R8 clear has no effect on critical", 4'b0101);
    sample(150);  check("R4 critical clears R8 pin follows", 4'b1100);
  endtask

  task automatic t_crit_only();
    write_reg(0, cfg_word(1, 2, 0, 1));
    sample(-100); check("R9 window ignored", 4'b1010);
    sample(201);  check("R9 critical asserts", 4'b0101);
    sample(200);  check("R9 critical released", 4'b1100);
  endtask

  task automatic t_enable();
    write_reg(0, cfg_word(0, 1, 0, 1));
    sample(300);  check("R10 disabled pin idle", 4'b1101);
    write_reg(0, cfg_word(1, 1, 0, 1));
    check("R10 enabling shows held event", 4'b0101);
  endtask

  task automatic t_window_off();
    sample(0);    check("R6 all clear", 4'b1000);
    write_reg(0, cfg_word(1, 1, 0, 0));
    sample(150);  check("R11 window off no pin", 4'b1100);
  endtask

  task automatic t_hyst_signed();
    write_reg(0, cfg_word(1, 1, 3, 1));
    sample(0);    check("R12 config write applied", 4'b1000);
    sample(201);  check("R4 critical set", 4'b0101);
    sample(177);  check("R4 code3 hysteresis holds", 4'b0101);
    sample(176);  check("R4 code3 hysteresis releases", 4'b0100);
    write_reg(1, 11'h7EC);   // -20
    write_reg(2, 11'h79C);   // -100
    sample(-60);  check("R12 limit write applied", 4'b1000);
    sample(5);    check("R2 signed compare vs negative upper", 4'b0100);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired: actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_upper_cmp();
    t_lower_cmp();
    t_interrupt();
    t_crit_int();
    t_crit_only();
    t_enable();
    t_window_off();
    t_hyst_signed();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule